// File: doc/BRIEF.md
# Command Ring-Buffer Pointer Controller

This block keeps the pointers of a circular command buffer held in memory. A producer fills the buffer in fixed 32-byte bursts, and a consumer drains it 32 bytes at a time. The block holds eight 32-bit quantities: the base address, the inclusive end address, the write pointer, the read pointer, a stored occupancy count, a breakpoint address, and high and low watermark levels. Software reaches each quantity as a pair of 16-bit registers on a simple word-addressed register bus. Writes take effect at the clock edge, and reads are combinational.

A burst strobe moves the write pointer forward and raises the count, but only while the link bit is set. The consume side is a valid/ready handshake. Ready is high whenever the count is non-zero, and a transfer happens in any cycle where valid and ready are both high. The consumer may hold valid for as long as it needs, and nothing is lost while ready is low. The block compares the count against the two watermarks, records a sticky overflow condition, and drives an interrupt from these flags under per-flag enables. When software sets the count to zero through its high half, the block emits a one-cycle reset pulse for the burst gatherer.

Top module: `cmdring_ctrl`

## Requirements
- R1: With the link bit (control register, address 0x01, bit 0) set, a `burst_i` cycle moves the write pointer (addresses 0x07/0x08) forward by 32. When the pointer already equals the end address (0x05/0x06), it is reloaded with the base address (0x03/0x04) instead. The same burst adds 32 to the stored count (0x0B/0x0C).
- R2: With the link bit clear, a `burst_i` cycle changes neither the write pointer nor the stored count.
- R3: Reading 0x0B/0x0C returns the low and high halves of a distance computed from the pointers. When write ≥ read it is write − read. Otherwise it is (end − read) + (write − base) + 32, taken modulo 2^32.
- R4: A write to the low half of base, end, write pointer, read pointer, count or breakpoint (0x0D/0x0E) stores the data ANDed with 0xFFE0. High halves, and both halves of the high watermark (0x0F/0x10) and the low watermark (0x11/0x12), store the full 16 bits. Odd addresses are high halves.
- R5: Writes have no effect on the status register (0x00), on the bounding-box registers (0x13–0x16, which read 0), on the constant 0x17 (which reads 4), or on the metrics registers (0x18–0x1F, which read 0). The clear register (0x02) reads 0.
- R6: A write to 0x0C whose merged count is zero makes `gath_rst_o` high for exactly the next cycle. No other write does this.
- R7: Status bit 0 is high when count ≥ high watermark, and bit 1 is high when count < low watermark.
- R8: `irq_o` is high exactly when an enabled flag is set. The enables are control bit 1 for status bit 0, control bit 2 for status bit 1, and control bit 3 for status bit 2.
- R9: `cons_ready_o` is high exactly when the count is non-zero. An accepted transfer moves the read pointer by 32 with the same inclusive-end wrap as R1 and lowers the count by 32. A valid held while ready is low changes nothing.
- R10: Status bit 2 (overflow) becomes set when a linked burst arrives while the count equals end − base, and it stays set. Writing a 1 to bit 2 of 0x02 clears it, unless a new overflow occurs in the same cycle.
- R11: A linked burst and an accepted transfer in the same cycle move both pointers and leave the count unchanged. A bus write to either half of a register replaces any strobe update of that register in the same cycle.
- R12: After reset every stored register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 5 | Register word address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | HW | Register write data |
| bus_rdata_o | output | HW | Register read data (combinational) |
| burst_i | input | 1 | Producer burst strobe |
| cons_valid_i | input | 1 | Consumer requests 32 bytes |
| cons_ready_o | output | 1 | Count non-zero, transfer accepted |
| gath_rst_o | output | 1 | One-cycle reset to the burst gatherer |
| irq_o | output | 1 | Enabled flag interrupt |

## Verification
The producer burst and the consumer transfer can land in the same cycle, and both update the shared count. Directed cases and random stimulus assert `burst_i` and `cons_valid_i` together, both with the count at zero and with it non-zero. The result is judged by reading back both pointers and the count, and by comparing them with a bench model that applies both updates. Bus writes that coincide with strobes are also provoked, to confirm that the written value wins for that register.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h01;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 5'h02;
  localparam logic [ADDR_W-1:0] A_PAIR0  = 5'h03;
  localparam logic [ADDR_W-1:0] A_CPV    = 5'h17;
  localparam logic [15:0] CPV_VALUE = 16'd4;

  localparam int unsigned NPAIR   = 8;
  localparam int unsigned NMASKED = 6;
  localparam int unsigned IX_BASE = 0;
  localparam int unsigned IX_END  = 1;
  localparam int unsigned IX_WPTR = 2;
  localparam int unsigned IX_RPTR = 3;
  localparam int unsigned IX_CNT  = 4;
  localparam int unsigned IX_BP   = 5;
  localparam int unsigned IX_HIWM = 6;
  localparam int unsigned IX_LOWM = 7;
  localparam logic [ADDR_W-1:0] A_LAST_PAIR = A_PAIR0 + ADDR_W'(2*NPAIR - 1);
  localparam logic [ADDR_W-1:0] A_CNT_HI = A_PAIR0 + ADDR_W'(2*IX_CNT + 1);

  localparam int unsigned CTL_LINK = 0;
  localparam int unsigned CTL_W    = 4;
  localparam int unsigned ST_HI    = 0;
  localparam int unsigned ST_LO    = 1;
  localparam int unsigned ST_OV    = 2;
  localparam int unsigned ST_W     = 3;
endpackage

// File: rtl/cmdring_step.sv
module cmdring_step #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 32
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] end_i,
  output logic [AW-1:0] nxt_o
);
  // inclusive end: wrap only once the pointer sits on the end address
  assign nxt_o = (ptr_i == end_i) ? base_i : ptr_i + AW'(STEP);
endmodule

// File: rtl/cmdring_dist.sv
module cmdring_dist #(
  parameter int unsigned AW    = 32,
  parameter int unsigned BURST = 32
) (
  input  logic [AW-1:0] wptr_i,
  input  logic [AW-1:0] rptr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] end_i,
  input  logic [AW-1:0] cnt_i,
  input  logic [AW-1:0] hiwm_i,
  input  logic [AW-1:0] lowm_i,
  output logic [AW-1:0] rd_dist_o,
  output logic          hi_o,
  output logic          lo_o
);
  logic [AW-1:0] wrapped;
  assign wrapped   = (end_i - rptr_i) + (wptr_i - base_i) + AW'(BURST);
  assign rd_dist_o = (wptr_i >= rptr_i) ? (wptr_i - rptr_i) : wrapped;
  assign hi_o      = cnt_i >= hiwm_i;
  assign lo_o      = cnt_i < lowm_i;
endmodule

// File: rtl/cmdring_ctrl.sv
module cmdring_ctrl
  import cmdring_pkg::*;
#(
  parameter int unsigned HW    = 16,
  parameter int unsigned BURST = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [HW-1:0]     bus_wdata_i,
  output logic [HW-1:0]     bus_rdata_o,
  input  logic              burst_i,
  input  logic              cons_valid_i,
  output logic              cons_ready_o,
  output logic              gath_rst_o,
  output logic              irq_o
);
  localparam int unsigned AW    = 2 * HW;
  localparam int unsigned ALIGN = $clog2(BURST);
  localparam logic [HW-1:0] LO_MASK = ~HW'((1 << ALIGN) - 1);

  logic [AW-1:0] regs_q  [NPAIR];
  logic [AW-1:0] upd_val [NPAIR];
  logic [NPAIR-1:0] upd_en, wr_lo, wr_hi;
  logic [CTL_W-1:0] ctrl_q;
  logic ovf_q;

  logic [AW-1:0] base_q, end_q, wptr_q, rptr_q, cnt_q;
  assign base_q = regs_q[IX_BASE];
  assign end_q  = regs_q[IX_END];
  assign wptr_q = regs_q[IX_WPTR];
  assign rptr_q = regs_q[IX_RPTR];
  assign cnt_q  = regs_q[IX_CNT];

  logic link;
  assign link = ctrl_q[CTL_LINK];

  logic acc_burst, acc_cons;
  assign cons_ready_o = cnt_q != '0;
  assign acc_burst    = burst_i & link;
  assign acc_cons     = cons_valid_i & cons_ready_o;

  logic [AW-1:0] wptr_nxt, rptr_nxt, rd_dist;
  logic hi_flag, lo_flag;

  cmdring_step #(.AW(AW), .STEP(BURST)) u_wstep (
    .ptr_i(wptr_q), .base_i(base_q), .end_i(end_q), .nxt_o(wptr_nxt));
  cmdring_step #(.AW(AW), .STEP(BURST)) u_rstep (
    .ptr_i(rptr_q), .base_i(base_q), .end_i(end_q), .nxt_o(rptr_nxt));

  cmdring_dist #(.AW(AW), .BURST(BURST)) u_dist (
    .wptr_i(wptr_q), .rptr_i(rptr_q), .base_i(base_q), .end_i(end_q),
    .cnt_i(cnt_q), .hiwm_i(regs_q[IX_HIWM]), .lowm_i(regs_q[IX_LOWM]),
    .rd_dist_o(rd_dist), .hi_o(hi_flag), .lo_o(lo_flag));

  // strobe-driven updates of the live registers
  always_comb begin
    for (int k = 0; k < int'(NPAIR); k++) begin
      upd_en[k]  = 1'b0;
      upd_val[k] = regs_q[k];
    end
    upd_en[IX_WPTR]  = acc_burst;
    upd_val[IX_WPTR] = wptr_nxt;
    upd_en[IX_RPTR]  = acc_cons;
    upd_val[IX_RPTR] = rptr_nxt;
    upd_en[IX_CNT]   = acc_burst | acc_cons;
    upd_val[IX_CNT]  = cnt_q + (acc_burst ? AW'(BURST) : '0)
                             - (acc_cons  ? AW'(BURST) : '0);
  end

  // register pairs: low half at even offset, high half at odd offset
  for (genvar i = 0; i < int'(NPAIR); i++) begin : g_pair
    localparam logic [ADDR_W-1:0] ALO = A_PAIR0 + ADDR_W'(2*i);
    localparam logic [HW-1:0] MASK = (i < int'(NMASKED)) ? LO_MASK : '1;
    assign wr_lo[i] = bus_wr_i && (bus_addr_i == ALO);
    assign wr_hi[i] = bus_wr_i && (bus_addr_i == ALO + ADDR_W'(1));
    always_ff @(posedge clk_i) begin
      if (!rst_ni)       regs_q[i] <= '0;
      else if (wr_lo[i]) regs_q[i] <= {regs_q[i][AW-1:HW], bus_wdata_i & MASK};
      else if (wr_hi[i]) regs_q[i] <= {bus_wdata_i, regs_q[i][HW-1:0]};
      else if (upd_en[i]) regs_q[i] <= upd_val[i];
    end
  end

  logic ovf_set, ovf_clr, cnt_zero_wr;
  assign ovf_set = acc_burst && (cnt_q == end_q - base_q);
  assign ovf_clr = bus_wr_i && (bus_addr_i == A_CLEAR) && bus_wdata_i[ST_OV];
  assign cnt_zero_wr = wr_hi[IX_CNT] && (bus_wdata_i == '0) && (cnt_q[HW-1:0] == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      ovf_q      <= 1'b0;
      gath_rst_o <= 1'b0;
    end else begin
      if (bus_wr_i && bus_addr_i == A_CTRL) ctrl_q <= bus_wdata_i[CTL_W-1:0];
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      gath_rst_o <= cnt_zero_wr;
    end
  end

  logic [ST_W-1:0] status;
  assign status = {ovf_q, lo_flag, hi_flag};
  assign irq_o  = |(status & ctrl_q[CTL_W-1:1]);

  // combinational read mux
  logic [ADDR_W-1:0] pair_off;
  logic [AW-1:0] pair_val;
  assign pair_off = bus_addr_i - A_PAIR0;
  always_comb begin
    pair_val = regs_q[pair_off[3:1]];
    if (pair_off[3:1] == 3'(IX_CNT)) pair_val = rd_dist;
    bus_rdata_o = '0;
    if (bus_addr_i == A_STATUS)      bus_rdata_o = HW'(status);
    else if (bus_addr_i == A_CTRL)   bus_rdata_o = HW'(ctrl_q);
    else if (bus_addr_i == A_CPV)    bus_rdata_o = HW'(CPV_VALUE);
    else if (bus_addr_i >= A_PAIR0 && bus_addr_i <= A_LAST_PAIR)
      bus_rdata_o = pair_off[0] ? pair_val[AW-1:HW] : pair_val[HW-1:0];
  end
endmodule

// File: rtl/cmdring_chk.sv
module cmdring_chk
  import cmdring_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned HW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [HW-1:0]     bus_wdata_i,
  input logic              burst_i,
  input logic              cons_valid_i,
  input logic              cons_ready_o,
  input logic              gath_rst_o,
  input logic              link_i,
  input logic [AW-1:0]     base_i,
  input logic [AW-1:0]     end_i,
  input logic [AW-1:0]     wptr_i,
  input logic [AW-1:0]     rptr_i,
  input logic [AW-1:0]     cnt_i,
  input logic              ovf_i
);
  assert_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_i && link_i && !bus_wr_i && wptr_i == end_i |=> wptr_i == $past(base_i));

  assert_nolink_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_i && !link_i && !bus_wr_i && !cons_valid_i |=> $stable(wptr_i) && $stable(cnt_i));

  assert_gath_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gath_rst_o |-> $past(bus_wr_i && bus_addr_i == A_CNT_HI && bus_wdata_i == '0));

  assert_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cons_valid_i && !cons_ready_o && !burst_i && !bus_wr_i |=> $stable(rptr_i) && $stable(cnt_i));

  assert_ovf_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> $past(burst_i && link_i && cnt_i == end_i - base_i));

  assert_both_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_i && link_i && cons_valid_i && cons_ready_o && !bus_wr_i |=> $stable(cnt_i));
endmodule

bind cmdring_ctrl cmdring_chk #(.AW(AW), .HW(HW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .burst_i(burst_i), .cons_valid_i(cons_valid_i),
  .cons_ready_o(cons_ready_o), .gath_rst_o(gath_rst_o), .link_i(link),
  .base_i(base_q), .end_i(end_q), .wptr_i(wptr_q), .rptr_i(rptr_q),
  .cnt_i(cnt_q), .ovf_i(ovf_q));

// File: tb/cmdring_ctrl_tb.sv
`timescale 1ns/1ps
module cmdring_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic wr = 1'b0, burst = 1'b0, cval = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic cready, grst, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmdring_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .burst_i(burst),
    .cons_valid_i(cval), .cons_ready_o(cready), .gath_rst_o(grst), .irq_o(irq));

  // bench model
  logic [31:0] m [8];
  logic [3:0] m_ctrl;
  logic m_ovf, m_grst;

  function automatic logic [31:0] adv(input logic [31:0] p);
    return (p == m[1]) ? m[0] : p + 32'd32;
  endfunction
  function automatic logic [31:0] rd_dist();
    return (m[2] >= m[3]) ? m[2] - m[3] : (m[1] - m[3]) + (m[2] - m[0]) + 32'd32;
  endfunction
  function automatic logic [2:0] m_status();
    return {m_ovf, m[4] < m[7], m[4] >= m[6]};
  endfunction
  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    logic [31:0] v;
    if (a == 5'h00) return {13'd0, m_status()};
    if (a == 5'h01) return {12'd0, m_ctrl};
    if (a >= 5'h03 && a <= 5'h12) begin
      v = (((a - 5'h03) >> 1) == 5'd4) ? rd_dist() : m[(a - 5'h03) >> 1];
      return ((a - 5'h03) & 5'h1) != 0 ? v[31:16] : v[15:0];
    end
    if (a == 5'h17) return 16'd4;
    return 16'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input logic [4:0] a, input logic [15:0] d,
                     input bit b, input bit c);
    logic [31:0] n [8];
    logic acc_b, acc_c;
    int idx;
    @(negedge clk);
    wr = w; addr = a; wdata = d; burst = b; cval = c;
    for (int k = 0; k < 8; k++) n[k] = m[k];
    acc_b = b && m_ctrl[0];
    acc_c = c && (m[4] != 0);
    if (acc_b) n[2] = adv(m[2]);
    if (acc_c) n[3] = adv(m[3]);
    n[4] = m[4] + (acc_b ? 32'd32 : 32'd0) - (acc_c ? 32'd32 : 32'd0);
    m_grst = 1'b0;
    @(posedge clk);
    #1;
    if (w && a == 5'h02 && d[2]) m_ovf = 1'b0;
    if (acc_b && m[4] == m[1] - m[0]) m_ovf = 1'b1;
    if (w && a == 5'h01) m_ctrl = d[3:0];
    if (w && a >= 5'h03 && a <= 5'h12) begin
      idx = int'((a - 5'h03) >> 1);
      if (((a - 5'h03) & 5'h1) != 0) begin
        n[idx] = {d, m[idx][15:0]};
        m_grst = (idx == 4) && (n[idx] == 0);
      end else n[idx] = {m[idx][31:16], (idx < 6) ? (d & 16'hFFE0) : d};
    end
    for (int k = 0; k < 8; k++) m[k] = n[k];
    wr = 1'b0; burst = 1'b0; cval = 1'b0;
    chk("R6 gatherer reset", grst, m_grst);
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a);
    @(negedge clk);
    addr = a; wr = 1'b0;
    #1;
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic chk_all(input string tag);
    for (int a = 0; a < 32; a++) rd_chk(tag, 5'(a));
  endtask

  task automatic chk_pins();
    @(negedge clk);
    #1;
    chk("R8 irq", irq, |(m_status() & m_ctrl[3:1]));
    chk("R9 ready", cready, m[4] != 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) m[k] = '0;
    m_ctrl = '0; m_ovf = 1'b0; m_grst = 1'b0;
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk_all("R12 reset");
    chk_pins();

    // R5 read-only space
    cyc(1, 5'h00, 16'hFFFF, 0, 0);
    cyc(1, 5'h13, 16'hFFFF, 0, 0);
    cyc(1, 5'h17, 16'hFFFF, 0, 0);
    cyc(1, 5'h1C, 16'hFFFF, 0, 0);
    rd_chk("R5 status", 5'h00); rd_chk("R5 bbox", 5'h13);
    rd_chk("R5 cpv", 5'h17); rd_chk("R5 metric", 5'h1C);

    // R4 alignment mask
    cyc(1, 5'h03, 16'h101F, 0, 0); chk("R4 base lo", exp_rd(5'h03), 16'h1000);
    cyc(1, 5'h05, 16'h10FF, 0, 0); chk("R4 end lo", exp_rd(5'h05), 16'h10E0);
    cyc(1, 5'h07, 16'h1000, 0, 0);
    cyc(1, 5'h09, 16'h1000, 0, 0);
    cyc(1, 5'h0D, 16'hABCD, 0, 0);
    cyc(1, 5'h0E, 16'hABCD, 0, 0);
    cyc(1, 5'h0F, 16'h00C7, 0, 0);
    cyc(1, 5'h11, 16'h0020, 0, 0);
    chk_all("R4 map");

    // R2 burst with link clear
    cyc(0, 5'h00, 0, 1, 0);
    rd_chk("R2 wptr", 5'h07); rd_chk("R2 count", 5'h0B);

    // R1 walk and wrap, R7/R8 flags
    cyc(1, 5'h01, 16'h000F, 0, 0);
    for (int k = 0; k < 8; k++) begin
      cyc(0, 5'h00, 0, 1, 0);
      rd_chk("R1 wptr", 5'h07);
      rd_chk("R3 distance", 5'h0B);
      rd_chk("R7 status", 5'h00);
      chk_pins();
    end
    chk("R1 wrapped", exp_rd(5'h07), 16'h1000);
    chk("R10 overflow seen", m_ovf, 1'b1);
    rd_chk("R10 status", 5'h00);
    cyc(1, 5'h02, 16'h0004, 0, 0);
    rd_chk("R10 cleared", 5'h00);

    // R9 consume with wrap; R3 wrapped formula
    for (int k = 0; k < 5; k++) begin
      cyc(0, 5'h00, 0, 0, 1);
      rd_chk("R9 rptr", 5'h09); rd_chk("R3 distance", 5'h0B);
    end
    // R11 simultaneous
    cyc(0, 5'h00, 0, 1, 1);
    rd_chk("R11 count", 5'h0B); rd_chk("R11 wptr", 5'h07); rd_chk("R11 rptr", 5'h09);
    cyc(1, 5'h07, 16'h1040, 1, 0);
    rd_chk("R11 bus wins", 5'h07);

    // R6 gatherer reset
    cyc(1, 5'h0B, 16'h0000, 0, 0);
    cyc(1, 5'h0C, 16'h0000, 0, 0);
    chk("R6 pulse", grst, 1'b1);
    cyc(0, 5'h00, 0, 0, 0);
    chk("R6 one cycle", grst, 1'b0);
    cyc(1, 5'h0C, 16'h0001, 0, 0);
    cyc(1, 5'h0C, 16'h0000, 0, 0);
    // R9 stall at zero
    cyc(0, 5'h00, 0, 0, 1);
    rd_chk("R9 stall rptr", 5'h09); chk_pins();

    // random phase
    cyc(1, 5'h07, 16'h1000, 0, 0);
    cyc(1, 5'h09, 16'h1000, 0, 0);
    for (int it = 0; it < 3000; it++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r == 0) cyc(1, 5'h01, 16'($urandom % 16) | 16'h1, 0, 0);
      else if (r == 1) cyc(1, 5'h02, 16'($urandom % 8), $urandom % 2, 0);
      else if (r == 2) cyc(1, 5'h0F, 16'($urandom % 16'h100), 0, 0);
      else if (r == 3) cyc(1, 5'h11, 16'($urandom % 16'h100), 0, $urandom % 2);
      else if (r == 4) cyc(1, 5'h01, 16'h0, 1, 0);
      else cyc(0, 5'h00, 0, $urandom % 2, $urandom % 2);
      chk_pins();
      if (it % 200 == 0) chk_all("R3 random readback");
    end
    chk_all("R11 final");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule